// File: doc/BRIEF.md
# Wake-Event Status Register

This block holds an eight-bit field of wake-related status flags in the upper byte of a 32-bit register word. Single-cycle strobes from the network side mark events: a link change, a wake-pattern frame, a frame that a receive filter matched, a test-only force indication, management-engine busy activity, and a generic wake event. Each strobe sets a sticky flag. Software clears a flag by writing a 1 to its bit position through a plain write port, and reads the whole field back on a combinational read port.

The lowest bit of the field is the power-management event status. Its value is also driven out as the mirrored status bit of the power-management control/status register. Clearing it also drops the registered PME output. When the block runs in CardBus mode, the same clear resets a general wake flag kept for the function event register. One level input reports whether on-chip management-frame handling is enabled, and the field shows that level as a read-only bit. Another bit position is reserved and always reads 0.

Top module: `wake_evt_status`

## Requirements
- R1: After reset every field bit, `pme_o` and `gen_wake_o` read 0, and `rd_data` bits outside 31..24 are always 0.
- R2: Bit 31 (link change) becomes 1 on the edge that samples `link_chg_i`=1 and stays 1 until cleared by writing 1 to it.
- R3: Bit 30 (wake-pattern frame) is set by `wake_frame_i` whatever the value of `pme_en_i`, and is cleared by writing 1 to it.
- R4: Bit 29 (filter-matched frame) is set by `filter_hit_i` and is cleared by writing 1 to it.
- R5: Bit 28 always reads 0. Bit 27 always equals `mgmt_mode_i`. Writes to bits 28 and 27 have no effect.
- R6: Bit 26 (forced test indication, `force_ind_i`) and bit 25 (management busy, `mgmt_busy_i`) are sticky and are cleared by writing 1 to them.
- R7: Bit 24 (PME status) is set by `wake_evt_i` whatever the value of `pme_en_i`, and `pme_stat_o` always equals bit 24.
- R8: A write with bit 24 = 1 and no wake event in the same cycle clears bit 24 and `pme_stat_o` on that edge, and `pme_o` falls on the following edge.
- R9: `gen_wake_o` is set by `wake_evt_i`. A write of 1 to bit 24 clears it only while `cardbus_i`=1; otherwise it holds.
- R10: When a set strobe and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R11: Writing 0 to a bit leaves that bit unchanged, and so does a cycle with `wr_en_i`=0.
- R12: `pme_o` equals the AND of bit 24 and `pme_en_i` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data; a 1 in bits 31..24 clears the matching flag |
| rd_data_o | output | 32 | Register read value; field in bits 31..24 |
| link_chg_i | input | 1 | Link status change strobe |
| wake_frame_i | input | 1 | Wake-pattern frame received strobe |
| filter_hit_i | input | 1 | Filter-matched frame strobe |
| force_ind_i | input | 1 | Test-only forced indication strobe |
| mgmt_busy_i | input | 1 | Management activity busy strobe |
| wake_evt_i | input | 1 | Generic wake event strobe |
| mgmt_mode_i | input | 1 | Level: on-chip management-frame handling enabled |
| pme_en_i | input | 1 | Level: PME output enable |
| cardbus_i | input | 1 | Level: CardBus mode |
| pme_stat_o | output | 1 | Mirrored PME status for the control/status register |
| pme_o | output | 1 | Registered PME output |
| gen_wake_o | output | 1 | General wake flag for the function event register |

## Verification
The bound assertions check properties that hold on every cycle. The reserved bit reads 0 and the management bit tracks its input. The PME mirror equals bit 24, and `pme_o` follows the previous cycle's status and enable. A strobe always leaves its flag set on the next edge, even when a clear hits the same cycle. Zero-writes never drop a flag, and `gen_wake_o` holds outside CardBus mode. Only the bench's scenarios show the end-to-end sequences. These include a write-1 clear followed one cycle later by `pme_o` falling, wake-pattern latching while PME is disabled, mixed multi-bit clears, and the difference between CardBus and non-CardBus clears of the general wake flag. The bench's reference model compares the full read word and all three side outputs on every cycle.

// File: rtl/wes_pkg.sv
package wes_pkg;

   localparam int FIELD_W = 8;

   // positions inside the field (LSB-relative); bit 0 must stay the PME status
   localparam int POS_LINK   = 7;
   localparam int POS_FRAME  = 6;
   localparam int POS_FILTER = 5;
   localparam int POS_RSVD   = 4;
   localparam int POS_MGMT   = 3;
   localparam int POS_FORCE  = 2;
   localparam int POS_BUSY   = 1;
   localparam int POS_PME    = 0;

   typedef enum logic [1:0] {
      KIND_STICKY = 2'd0,
      KIND_ZERO   = 2'd1,
      KIND_LEVEL  = 2'd2
   } bit_kind_e;

   function automatic bit_kind_e kind_of(input int pos);
      if (pos == POS_RSVD)      return KIND_ZERO;
      else if (pos == POS_MGMT) return KIND_LEVEL;
      else                      return KIND_STICKY;
   endfunction

endpackage

// File: rtl/wes_sticky_cell.sv
module wes_sticky_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_d;

   generate
      if (SET_WINS) begin : g_set_prio
         always_comb q_d = set_i | (q_o & ~clr_i);
      end else begin : g_clr_prio
         always_comb q_d = (set_i | q_o) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_d;
   end
endmodule

// File: rtl/wes_pme_ctrl.sv
module wes_pme_ctrl #(
   parameter bit GATE_GW_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_i,
   input  logic pme_en_i,
   input  logic stat_clr_i,
   input  logic wake_evt_i,
   input  logic cardbus_i,
   output logic pme_o,
   output logic gen_wake_o
);
   logic gw_clr;

   generate
      if (GATE_GW_CLR) begin : g_gated
         assign gw_clr = stat_clr_i & cardbus_i;
      end else begin : g_always
         logic unused_cb;
         assign unused_cb = cardbus_i;
         assign gw_clr    = stat_clr_i;
      end
   endgenerate

   wes_sticky_cell #(.SET_WINS(1'b1)) u_gw (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(wake_evt_i),
      .clr_i(gw_clr),
      .q_o  (gen_wake_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pme_o <= 1'b0;
      else        pme_o <= stat_i & pme_en_i;
   end
endmodule

// File: rtl/wake_evt_status.sv
module wake_evt_status
   import wes_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int FIELD_LSB   = 24,
   parameter bit GATE_GW_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             link_chg_i,
   input  logic             wake_frame_i,
   input  logic             filter_hit_i,
   input  logic             force_ind_i,
   input  logic             mgmt_busy_i,
   input  logic             wake_evt_i,
   input  logic             mgmt_mode_i,
   input  logic             pme_en_i,
   input  logic             cardbus_i,
   output logic             pme_stat_o,
   output logic             pme_o,
   output logic             gen_wake_o
);
   localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   generate
      if (FIELD_MSB >= REG_W || FIELD_LSB < 0) begin : g_bad_cfg
         $error("wake_evt_status: field does not fit in register");
      end
   endgenerate

   logic [FIELD_W-1:0] set_vec;
   logic [FIELD_W-1:0] clr_vec;
   logic [FIELD_W-1:0] fld;

   always_comb begin
      set_vec              = '0;
      set_vec[POS_LINK]    = link_chg_i;
      set_vec[POS_FRAME]   = wake_frame_i;
      set_vec[POS_FILTER]  = filter_hit_i;
      set_vec[POS_FORCE]   = force_ind_i;
      set_vec[POS_BUSY]    = mgmt_busy_i;
      set_vec[POS_PME]     = wake_evt_i;
   end

   assign clr_vec = wr_en_i ? wr_data_i[FIELD_MSB:FIELD_LSB] : '0;

   generate
      for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
         if (kind_of(k) == KIND_STICKY) begin : g_sticky
            wes_sticky_cell #(.SET_WINS(1'b1)) u_cell (
               .clk  (clk),
               .rst_n(rst_n),
               .set_i(set_vec[k]),
               .clr_i(clr_vec[k]),
               .q_o  (fld[k])
            );
         end else if (kind_of(k) == KIND_LEVEL) begin : g_level
            assign fld[k] = mgmt_mode_i;
         end else begin : g_zero
            assign fld[k] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      rd_data_o                      = '0;
      rd_data_o[FIELD_MSB:FIELD_LSB] = fld;
   end

   assign pme_stat_o = fld[POS_PME];

   wes_pme_ctrl #(.GATE_GW_CLR(GATE_GW_CLR)) u_pme (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_i    (fld[POS_PME]),
      .pme_en_i  (pme_en_i),
      .stat_clr_i(clr_vec[POS_PME]),
      .wake_evt_i(wake_evt_i),
      .cardbus_i (cardbus_i),
      .pme_o     (pme_o),
      .gen_wake_o(gen_wake_o)
   );
endmodule

// File: rtl/wake_evt_status_chk.sv
module wake_evt_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en_i,
   input logic [31:0] wr_data_i,
   input logic [31:0] rd_data_o,
   input logic        link_chg_i,
   input logic        wake_evt_i,
   input logic        mgmt_mode_i,
   input logic        pme_en_i,
   input logic        cardbus_i,
   input logic        pme_stat_o,
   input logic        pme_o,
   input logic        gen_wake_o
);
   a_r2_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
      link_chg_i |=> rd_data_o[31]);

   a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[28] == 1'b0);

   a_r5_mgmt_level: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[27] == mgmt_mode_i);

   a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      pme_stat_o == rd_data_o[24]);

   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[24] && !wake_evt_i) |=> !rd_data_o[24]);

   a_r9_gw_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cardbus_i && gen_wake_o) |=> gen_wake_o);

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[31] && link_chg_i) |=> rd_data_o[31]);

   a_r11_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[31] && !(wr_en_i && wr_data_i[31])) |=> rd_data_o[31]);

   a_r12_pme_out: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (pme_o == ($past(rd_data_o[24]) && $past(pme_en_i))));
endmodule

bind wake_evt_status wake_evt_status_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .rd_data_o  (rd_data_o),
   .link_chg_i (link_chg_i),
   .wake_evt_i (wake_evt_i),
   .mgmt_mode_i(mgmt_mode_i),
   .pme_en_i   (pme_en_i),
   .cardbus_i  (cardbus_i),
   .pme_stat_o (pme_stat_o),
   .pme_o      (pme_o),
   .gen_wake_o (gen_wake_o)
);

// File: tb/wake_evt_status_tb_top.sv
`timescale 1ns/1ps
module wake_evt_status_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        link_chg = 0, wake_frame = 0, filter_hit = 0, force_ind = 0;
   logic        mgmt_busy = 0, wake_evt = 0, mgmt_mode = 0, pme_en = 0, cardbus = 0;
   logic        pme_stat, pme, gen_wake;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // reference model state
   logic [7:0] m_st = '0;
   logic       m_pme = 0;
   logic       m_gw  = 0;

   always #2 clk = ~clk;

   wake_evt_status dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .link_chg_i(link_chg), .wake_frame_i(wake_frame),
      .filter_hit_i(filter_hit), .force_ind_i(force_ind), .mgmt_busy_i(mgmt_busy),
      .wake_evt_i(wake_evt), .mgmt_mode_i(mgmt_mode), .pme_en_i(pme_en),
      .cardbus_i(cardbus), .pme_stat_o(pme_stat), .pme_o(pme), .gen_wake_o(gen_wake)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input int k);
      case (k)
         7: return "R2";
         6: return "R3";
         5: return "R4";
         4: return "R5";
         3: return "R5";
         2: return "R6";
         1: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [31:0] exp_rd();
      logic [7:0] f;
      f = m_st;
      f[4] = 1'b0;
      f[3] = mgmt_mode;
      return {f, 24'h0};
   endfunction

   // one clock: model follows the inputs held across the edge, then compare
   task automatic cyc();
      logic [7:0] setv, clrv;
      @(negedge clk);
      if (!rst_n) begin
         m_st = '0; m_pme = 0; m_gw = 0;
      end else begin
         setv = {link_chg, wake_frame, filter_hit, 2'b00, force_ind, mgmt_busy, wake_evt};
         clrv = wr_en ? wr_data[31:24] : 8'h00;
         m_pme = m_st[0] && pme_en;
         m_gw  = wake_evt || (m_gw && !(clrv[0] && cardbus));
         for (int k = 0; k < 8; k++)
            if (k != 3 && k != 4) m_st[k] = setv[k] | (m_st[k] & ~clrv[k]);
      end
      for (int k = 0; k < 8; k++)
         check(req_of(k), {31'h0, rd_data[24+k]}, {31'h0, exp_rd()[24+k]});
      check("R1", {8'h0, rd_data[23:0]}, 32'h0);
      check("R7", {31'h0, pme_stat}, {31'h0, m_st[0]});
      check("R12", {31'h0, pme}, {31'h0, m_pme});
      check("R9", {31'h0, gen_wake}, {31'h0, m_gw});
   endtask

   task automatic quiet();
      wr_en = 0; wr_data = '0;
      {link_chg, wake_frame, filter_hit, force_ind, mgmt_busy, wake_evt} = '0;
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en = 1; wr_data = {b, 24'hFF_FFFF};
   endtask

   initial begin
      repeat (3) cyc();
      check("R1", rd_data, 32'h0);            // R1 reset state
      check("R1", {30'h0, pme, gen_wake}, 32'h0);
      rst_n = 1'b1;
      cyc();

      // R2 / R3 / R4 / R6 set from individual strobes, PME disabled
      link_chg = 1; cyc(); quiet(); cyc();
      wake_frame = 1; cyc(); quiet(); cyc();   // R3 latches with pme_en=0
      filter_hit = 1; force_ind = 1; mgmt_busy = 1; cyc(); quiet(); cyc();
      check("R3", {31'h0, rd_data[30]}, 32'h1);

      // R11 zero writes and idle cycles change nothing
      wr(8'h00); cyc(); quiet(); cyc();
      check("R11", rd_data, 32'hE600_0000);

      // R5 writes to reserved / read-only bits, mgmt level tracking
      mgmt_mode = 1; wr(8'h18); cyc(); quiet(); cyc();
      check("R5", {31'h0, rd_data[27]}, 32'h1);
      mgmt_mode = 0; cyc();

      // multi-bit clears
      wr(8'hA2); cyc(); quiet(); cyc();
      wr(8'h44); cyc(); quiet(); cyc();

      // R7/R8/R12 PME path with enable
      pme_en = 1; wake_evt = 1; cyc(); quiet(); cyc(); cyc();
      check("R12", {31'h0, pme}, 32'h1);
      wr(8'h01); cyc();
      check("R8", {31'h0, pme_stat}, 32'h0);   // status falls on the write edge
      check("R8", {31'h0, pme}, 32'h1);        // output still high one cycle
      quiet(); cyc();
      check("R8", {31'h0, pme}, 32'h0);

      // R9 gen wake: non-CardBus clear holds it, CardBus clear drops it
      check("R9", {31'h0, gen_wake}, 32'h1);
      cardbus = 0; wake_evt = 1; cyc(); quiet(); cyc();
      wr(8'h01); cyc(); quiet(); cyc();
      check("R9", {31'h0, gen_wake}, 32'h1);
      cardbus = 1; wr(8'h01); cyc(); quiet(); cyc();
      check("R9", {31'h0, gen_wake}, 32'h0);

      // R10 set and clear in the same cycle
      link_chg = 1; wake_evt = 1; wr(8'h81); cyc(); quiet(); cyc();
      check("R10", {30'h0, rd_data[31], rd_data[24]}, 32'h3);

      // R7 wake event with PME disabled still sets status
      pme_en = 0; wr(8'hFF); cyc(); quiet(); cyc();
      wake_evt = 1; cyc(); quiet(); cyc(); cyc();
      check("R7", {31'h0, rd_data[24]}, 32'h1);

      // pseudo-random mix
      for (int i = 0; i < 300; i++) begin
         logic [15:0] r;
         r = 16'($urandom());
         {link_chg, wake_frame, filter_hit, force_ind, mgmt_busy, wake_evt} = r[5:0] & r[11:6];
         mgmt_mode = r[12]; pme_en = r[13]; cardbus = r[14];
         wr_en = r[15]; wr_data = {8'($urandom()), 24'($urandom())};
         cyc();
      end
      quiet(); cyc();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule